// File: doc/BRIEF.md
# Decade Time Base Coincidence Detector

The block counts time-base pulses into a chain of BCD decades while a count-gate input is held high. The chain is compared with a selected decimal target. A coincidence flag rises when the count reaches that target. The flag then freezes the chain and stays high until reset, so it can close a measurement gate elsewhere on the chip.

One case needs its own handling. When every target digit is zero, the comparison already holds at reset, before a single pulse has been counted. In that case the comparison is not used. A separate latch is set by the carry out of the most significant decade instead, so coincidence marks a full revolution of the chain. Reset clears this latch asynchronously, so it always wins over a carry arriving at the same moment. Ordering is fully synchronous and no delay elements are used.

Top module: `decade_match_timer`

## Requirements
- R1: While rst_n is low, and on the first edges after it rises with no counted pulse, count reads all zeros and match reads 0.
- R2: count holds one BCD digit per 4-bit field, digit 0 in bits [3:0] being least significant. Every digit stays within 0..9. A digit that advances from 9 returns to 0 and advances the next digit on the same edge.
- R3: Digit 0 advances on a rising clk edge only when gate_en and tick are both high at that edge and coincidence is not held. Otherwise count keeps its value.
- R4: With a nonzero target whose digits are all 0..9, match rises on the first edge after count equals target. No pulse advances count once it equals target.
- R5: With an all-zero target, the comparison does not raise match. match rises on the edge at which the top decade carries, which is the edge where count wraps from all nines to all zeros.
- R6: Once high, match stays high, and count stays frozen, until rst_n is driven low.
- R7: A target containing a digit above 9 never matches. Counting continues and wraps through all zeros without raising match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Count gate; pulses are counted only while high |
| tick | input | 1 | Time-base pulse, one clock wide per count |
| target | input | 4*NUM_DEC | Selected BCD target, digit 0 in the low nibble |
| match | output | 1 | Sticky coincidence flag |
| count | output | 4*NUM_DEC | BCD contents of the decade chain |

## Verification
A counted pulse changes count on the same edge that samples it, and the result is read at the following falling edge. A target reached by the comparison raises match one edge later. In the all-zero target case, match rises on the very edge at which count wraps to zero. The bench holds a decimal reference model that it updates at every rising edge and compares with both outputs at every falling edge. Because of this, each of these latencies is checked on the exact cycle it is due. Phases run with a continuous pulse stream, with a gated and decimated pulse stream, with an all-zero target and with an unreachable target.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef logic [3:0] digit_t;
  localparam digit_t DIGIT_MAX = 4'd9;
  localparam digit_t DIGIT_MIN = 4'd0;
endpackage

// File: rtl/dmt_decade.sv
module dmt_decade
  import dmt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv_i,
  output digit_t q_o,
  output logic   carry_o
);
  digit_t q_r;
  digit_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (adv_i) begin
      if (q_r == DIGIT_MAX) q_nxt = DIGIT_MIN;
      else                  q_nxt = q_r + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= DIGIT_MIN;
    else if (adv_i) q_r <= q_nxt;
  end

  assign q_o     = q_r;
  assign carry_o = adv_i && (q_r == DIGIT_MAX);

  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_r <= DIGIT_MAX);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && q_r == DIGIT_MAX) |=> (q_r == DIGIT_MIN));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(q_r));
endmodule

// File: rtl/dmt_match.sv
module dmt_match
  import dmt_pkg::*;
#(
  parameter int NUM_DEC = 4,
  localparam int W = 4 * NUM_DEC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] target_i,
  input  logic         top_carry_i,
  output logic         hold_o,
  output logic         match_o
);
  logic [NUM_DEC-1:0] dig_eq;
  logic [NUM_DEC-1:0] dig_zero;
  logic all_eq, zero_tgt, hit_now;
  logic norm_q, wrap_q, norm_nxt, wrap_nxt;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_cmp
    assign dig_eq[i]   = count_i[4*i +: 4] == target_i[4*i +: 4];
    assign dig_zero[i] = target_i[4*i +: 4] == DIGIT_MIN;
  end

  assign all_eq   = &dig_eq;
  assign zero_tgt = &dig_zero;
  assign hit_now  = all_eq && !zero_tgt;

  always_comb begin
    norm_nxt = norm_q | hit_now;
    wrap_nxt = wrap_q | (top_carry_i && zero_tgt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      norm_q <= norm_nxt;
      wrap_q <= wrap_nxt;
    end
  end

  assign match_o = norm_q | wrap_q;
  assign hold_o  = match_o | hit_now;

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> match_o);
  p_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> match_o);
  p_zero_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_tgt && !top_carry_i && !match_o) |=> !match_o);
endmodule

// File: rtl/decade_match_timer.sv
module decade_match_timer
  import dmt_pkg::*;
#(
  parameter int NUM_DEC = 4,
  localparam int W = 4 * NUM_DEC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_en,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic         match,
  output logic [W-1:0] count
);
  logic [NUM_DEC-1:0] adv;
  logic [NUM_DEC-1:0] carry;
  logic hold;

  assign adv[0] = gate_en && tick && !hold;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    if (i > 0) begin : g_chain
      assign adv[i] = carry[i-1];
    end
    dmt_decade u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (adv[i]),
      .q_o     (count[4*i +: 4]),
      .carry_o (carry[i])
    );
  end

  dmt_match #(.NUM_DEC(NUM_DEC)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_i     (count),
    .target_i    (target),
    .top_carry_i (carry[NUM_DEC-1]),
    .hold_o      (hold),
    .match_o     (match)
  );

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> $stable(count));
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en && tick) |=> $stable(count));
endmodule

// File: tb/decade_match_timer_bench.sv
module decade_match_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam int W = 4 * ND;
  localparam int MODV = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b0;
  logic tick = 1'b0;
  logic [W-1:0] target = '0;
  logic match;
  logic [W-1:0] count;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  int m_cnt = 0;
  bit m_match = 1'b0;

  decade_match_timer #(.NUM_DEC(ND)) u_decade_match_timer (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .tick(tick),
    .target(target), .match(match), .count(count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r = '0;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int tgt_val(logic [W-1:0] t);
    int v = 0;
    for (int i = ND-1; i >= 0; i--) begin
      if (t[4*i +: 4] > 4'd9) return -1;
      v = v * 10 + int'(t[4*i +: 4]);
    end
    return v;
  endfunction

  // Reference model, decimal arithmetic
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt   <= 0;
      m_match <= 1'b0;
    end else begin
      automatic int tv = tgt_val(target);
      automatic bit eqn = (tv > 0) && (m_cnt == tv);
      automatic bit hld = m_match || eqn;
      automatic bit mm  = m_match || eqn;
      automatic int nc  = m_cnt;
      if (gate_en && tick && !hld) begin
        if (m_cnt == MODV - 1) begin
          nc = 0;
          if (tv == 0) mm = 1'b1;
        end else nc = m_cnt + 1;
      end
      m_cnt   <= nc;
      m_match <= mm;
    end
  end

  task automatic check(string req, logic [W-1:0] ac, logic [W-1:0] ex,
                       logic am, logic em);
    n_cmp++;
    if (ac !== ex || am !== em) begin
      n_bad++;
      $display("FAIL %s t=%0t count=%h exp %h match=%b exp %b",
               req, $time, ac, ex, am, em);
    end
  endtask

  always @(negedge clk) check(cur_req, count, to_bcd(m_cnt), match, m_match);

  task automatic restart(logic [W-1:0] t, string req);
    @(posedge clk); #1;
    rst_n = 1'b0; gate_en = 1'b0; tick = 1'b0; target = t;
    cur_req = "R1";
    @(posedge clk); #1;
    check("R1", count, '0, match, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", count, '0, match, 1'b0);
    cur_req = req;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (mode == 0) begin gate_en = 1'b1; tick = 1'b1; end
      else begin gate_en = (i % 3) != 0; tick = (i % 2) == 0; end
    end
    @(posedge clk); #1;
    gate_en = 1'b0; tick = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    // R4 continuous pulses to 0025, then R6 hold
    restart(16'h0025, "R4");
    run(24, 0);
    @(negedge clk);
    check("R4", count, 16'h0024, match, 1'b0);
    run(30, 0);
    @(negedge clk);
    check("R6", count, 16'h0025, match, 1'b1);
    // R3 gated, decimated pulses; R2 carries between digits
    restart(16'h0123, "R3");
    run(800, 1);
    @(negedge clk);
    check("R2", count, 16'h0123, match, 1'b1);
    // R5 all-zero target: full revolution
    restart(16'h0000, "R5");
    run(MODV - 1, 0);
    @(negedge clk);
    check("R5", count, 16'h9999, match, 1'b0);
    run(4, 0);
    @(negedge clk);
    check("R5", count, 16'h0000, match, 1'b1);
    // R7 unreachable target wraps without match
    restart(16'hA000, "R7");
    run(MODV + 7, 0);
    @(negedge clk);
    check("R7", count, to_bcd(m_cnt), match, 1'b0);
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule